// File: doc/BRIEF.md
# Light-Load PWM/PFM Mode Controller

This block supervises one buck regulator channel and decides whether it regulates with fixed-frequency PWM or switches to pulse-frequency mode (PFM) when the load is light. The switching engine strobes it once per switching cycle with a digitised load-current sample. The block compares each sample with a programmed threshold. It moves to PFM only after a programmed run of consecutive low-current cycles. The length of that run sits in a writable register that resets to 20.

While in PFM, the block holds the duty value that the compensator last produced in PWM and presents it to the modulator, so the compensator stays frozen. It watches three voltage-comparator flags. Each fresh drop of the output below the reference produces a single trigger pulse to the modulator, unless the modulator is still busy with a cycle. If the output leaves the window around the reference, either high or low, the block returns to PWM at once. The block also turns the reference and two programmable offsets into the window limits for the comparators. It measures the idle gap between the end of one PFM pulse and the next trigger, and it marks every mode change with a one-cycle pulse.

Top module: `lightload_mode_ctrl`

## Requirements
- R1: After synchronous reset, `pfm_mode` is 0, `mode_chg`, `pfm_trig` and `dead_zone_ticks` are 0, and the entry-run register holds 20.
- R2: With `cfg_pfm_en` high in PWM, the block enters PFM (`pfm_mode`=1) at the clock edge that samples the Nth consecutive strobe with `cur_sample` < `cfg_cur_thresh`. N is the entry-run register.
- R3: A strobe whose sample is at or above the threshold restarts the consecutive-cycle run from zero.
- R4: A clock with `cfg_entry_we` high loads `cfg_entry_cycles` into the entry-run register. A stored value of 0 behaves as 1.
- R5: While `cfg_pfm_en` is low, the block stays in PWM. If `cfg_pfm_en` is sampled low while the block is in PFM, it returns to PWM at that edge.
- R6: In PWM, `duty_out` equals `pwm_duty`. In PFM, `duty_out` holds the `pwm_duty` value sampled at the entry edge and ignores later changes.
- R7: In PFM, `pfm_trig` pulses for exactly one cycle, in the cycle after an edge that sees `cmp_below_ref` go from 0 to 1 while `mod_busy` is 0. A rising edge seen while busy is dropped. No trigger is issued in PWM.
- R8: In PFM, an edge that samples `cmp_above_hi` or `cmp_below_lo` high returns the block to PWM. No trigger is issued for that edge, even if `cmp_below_ref` rises at the same time.
- R9: `win_hi_lim` = `vref_code` + `cfg_win_hi`, saturated at the maximum code. `win_lo_lim` = `vref_code` − `cfg_win_lo`, floored at 0. Both are combinational.
- R10: With each trigger, `dead_zone_ticks` captures the number of clock edges that sampled `mod_busy` low since it was last sampled high. The value is held between triggers.
- R11: `mode_chg` is high for exactly one cycle after every change of `pfm_mode`, and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_pfm_en | input | 1 | Allows light-load mode |
| cfg_cur_thresh | input | CUR_W | Light-load current threshold |
| cfg_entry_we | input | 1 | Write strobe for the entry-run register |
| cfg_entry_cycles | input | CNT_W | New entry-run length |
| cfg_win_hi | input | OFF_W | Upper window offset above reference |
| cfg_win_lo | input | OFF_W | Lower window offset below reference |
| vref_code | input | REF_W | Reference code |
| cyc_strobe | input | 1 | One pulse per switching cycle, qualifies `cur_sample` |
| cur_sample | input | CUR_W | Digitised load current |
| pwm_duty | input | DUTY_W | Duty from the compensator |
| cmp_below_ref | input | 1 | Output below reference |
| cmp_above_hi | input | 1 | Output above upper limit |
| cmp_below_lo | input | 1 | Output below lower limit |
| mod_busy | input | 1 | Modulator is running a cycle |
| pfm_mode | output | 1 | 1 in PFM; also freezes the compensator |
| mode_chg | output | 1 | One-cycle pulse on each mode change |
| pfm_trig | output | 1 | One-cycle request for a PFM switching cycle |
| duty_out | output | DUTY_W | Duty presented to the modulator |
| win_hi_lim | output | REF_W | Upper comparator limit |
| win_lo_lim | output | REF_W | Lower comparator limit |
| dead_zone_ticks | output | DZ_W | Last measured idle gap in clocks |

## Verification
Two things can land on the same edge: the trigger decision, when `cmp_below_ref` rises, and the PFM exit, when a window flag is set. The bench raises `cmp_below_ref` together with `cmp_below_lo`, and separately together with `cmp_above_hi`, on a single clock. It then expects `pfm_mode` to fall with a `mode_chg` pulse and `pfm_trig` to stay low. A second overlap, a fresh falling edge while `mod_busy` is high, is driven directly and must produce no trigger, then and after the busy flag clears.

// File: rtl/lightload_pkg.sv
package lightload_pkg;

    localparam int unsigned DEF_ENTRY_RUN = 20;

    typedef enum logic {
        MODE_PWM = 1'b0,
        MODE_PFM = 1'b1
    } reg_mode_e;

    typedef struct packed {
        logic below_ref;
        logic above_hi;
        logic below_lo;
    } win_flags_t;

    function automatic logic [31:0] sat_incr(input logic [31:0] val, input logic [31:0] top);
        return (val >= top) ? top : val + 32'd1;
    endfunction

endpackage

// File: rtl/llm_entry_run.sv
module llm_entry_run #(
    parameter int unsigned CUR_W   = 10,
    parameter int unsigned CNT_W   = 8,
    parameter int unsigned DEF_RUN = lightload_pkg::DEF_ENTRY_RUN
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             arm,
    input  logic             strobe,
    input  logic [CUR_W-1:0] sample,
    input  logic [CUR_W-1:0] thresh,
    input  logic             limit_we,
    input  logic [CNT_W-1:0] limit_wdata,
    output logic             enter_req
);
    import lightload_pkg::*;

    localparam logic [CNT_W-1:0] DEF_V   = CNT_W'(DEF_RUN);
    localparam logic [CNT_W-1:0] RUN_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] limit_q;
    logic [CNT_W-1:0] run_q;
    logic [CNT_W-1:0] limit_eff;
    logic [CNT_W:0]   run_plus;
    logic             low_cur;

    assign low_cur   = sample < thresh;
    assign limit_eff = (limit_q == '0) ? CNT_W'(1) : limit_q;
    assign run_plus  = {1'b0, run_q} + (CNT_W+1)'(1);
    assign enter_req = arm && strobe && low_cur && (run_plus >= {1'b0, limit_eff});

    always_ff @(posedge clk) begin
        if (rst) begin
            limit_q <= DEF_V;
        end else if (limit_we) begin
            limit_q <= limit_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !arm) begin
            run_q <= '0;
        end else if (strobe) begin
            if (!low_cur || enter_req) begin
                run_q <= '0;
            end else begin
                run_q <= CNT_W'(sat_incr(32'(run_q), 32'(RUN_MAX)));
            end
        end
    end

    assert_run_cleared_R3: assert property (@(posedge clk) disable iff (rst)
        (arm && strobe && !low_cur) |=> (run_q == '0));

    assert_run_below_limit_R2: assert property (@(posedge clk) disable iff (rst)
        (arm && !limit_we && $stable(limit_q)) |-> (run_q < limit_eff));

endmodule

// File: rtl/llm_window.sv
module llm_window #(
    parameter int unsigned REF_W = 10,
    parameter int unsigned OFF_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [REF_W-1:0] vref,
    input  logic [OFF_W-1:0] hi_off,
    input  logic [OFF_W-1:0] lo_off,
    output logic [REF_W-1:0] lim_hi,
    output logic [REF_W-1:0] lim_lo
);
    localparam int unsigned EXT_W = ((REF_W > OFF_W) ? REF_W : OFF_W) + 1;

    logic [EXT_W-1:0] vref_x;
    logic [EXT_W-1:0] hi_x;
    logic [EXT_W-1:0] lo_x;
    logic [EXT_W-1:0] sum_x;
    logic [EXT_W-1:0] ref_max_x;

    assign vref_x    = EXT_W'(vref);
    assign hi_x      = EXT_W'(hi_off);
    assign lo_x      = EXT_W'(lo_off);
    assign ref_max_x = EXT_W'({REF_W{1'b1}});
    assign sum_x     = vref_x + hi_x;

    always_comb begin
        lim_hi = (sum_x > ref_max_x) ? {REF_W{1'b1}} : REF_W'(sum_x);
        lim_lo = (lo_x > vref_x) ? '0 : REF_W'(vref_x - lo_x);
    end

    assert_hi_not_below_ref_R9: assert property (@(posedge clk) disable iff (rst)
        lim_hi >= vref);

    assert_lo_not_above_ref_R9: assert property (@(posedge clk) disable iff (rst)
        lim_lo <= vref);

endmodule

// File: rtl/llm_pfm_trigger.sv
module llm_pfm_trigger #(
    parameter int unsigned DZ_W = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            pfm_active,
    input  logic            below_ref,
    input  logic            busy,
    output logic            trig,
    output logic [DZ_W-1:0] dz_ticks
);
    import lightload_pkg::*;

    localparam logic [DZ_W-1:0] DZ_MAX = {DZ_W{1'b1}};

    logic            below_q;
    logic            fire;
    logic [DZ_W-1:0] dz_cnt;

    assign fire = pfm_active && below_ref && !below_q && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            below_q <= 1'b0;
            trig    <= 1'b0;
        end else begin
            below_q <= below_ref;
            trig    <= fire;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || busy) begin
            dz_cnt <= '0;
        end else begin
            dz_cnt <= DZ_W'(sat_incr(32'(dz_cnt), 32'(DZ_MAX)));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dz_ticks <= '0;
        end else if (fire) begin
            dz_ticks <= dz_cnt;
        end
    end

    assert_trig_gated_R7: assert property (@(posedge clk) disable iff (rst)
        trig |-> ($past(pfm_active) && !$past(busy) && $past(below_ref)));

    assert_trig_one_shot_R7: assert property (@(posedge clk) disable iff (rst)
        trig |=> !trig);

    assert_dz_held_R10: assert property (@(posedge clk) disable iff (rst)
        !trig |-> $stable(dz_ticks));

endmodule

// File: rtl/lightload_mode_ctrl.sv
module lightload_mode_ctrl #(
    parameter int unsigned CUR_W   = 10,
    parameter int unsigned CNT_W   = 8,
    parameter int unsigned REF_W   = 10,
    parameter int unsigned OFF_W   = 8,
    parameter int unsigned DUTY_W  = 12,
    parameter int unsigned DZ_W    = 16,
    parameter int unsigned DEF_RUN = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_pfm_en,
    input  logic [CUR_W-1:0]  cfg_cur_thresh,
    input  logic              cfg_entry_we,
    input  logic [CNT_W-1:0]  cfg_entry_cycles,
    input  logic [OFF_W-1:0]  cfg_win_hi,
    input  logic [OFF_W-1:0]  cfg_win_lo,
    input  logic [REF_W-1:0]  vref_code,
    input  logic              cyc_strobe,
    input  logic [CUR_W-1:0]  cur_sample,
    input  logic [DUTY_W-1:0] pwm_duty,
    input  logic              cmp_below_ref,
    input  logic              cmp_above_hi,
    input  logic              cmp_below_lo,
    input  logic              mod_busy,
    output logic              pfm_mode,
    output logic              mode_chg,
    output logic              pfm_trig,
    output logic [DUTY_W-1:0] duty_out,
    output logic [REF_W-1:0]  win_hi_lim,
    output logic [REF_W-1:0]  win_lo_lim,
    output logic [DZ_W-1:0]   dead_zone_ticks
);
    import lightload_pkg::*;

    reg_mode_e         mode_q;
    logic              chg_q;
    logic [DUTY_W-1:0] duty_hold_q;
    win_flags_t        flags;
    logic              in_pfm;
    logic              exit_now;
    logic              enter_req;
    logic              pfm_active;

    assign flags      = '{below_ref: cmp_below_ref, above_hi: cmp_above_hi, below_lo: cmp_below_lo};
    assign in_pfm     = (mode_q == MODE_PFM);
    assign exit_now   = in_pfm && (!cfg_pfm_en || flags.above_hi || flags.below_lo);
    assign pfm_active = in_pfm && !exit_now;

    llm_entry_run #(
        .CUR_W   (CUR_W),
        .CNT_W   (CNT_W),
        .DEF_RUN (DEF_RUN)
    ) u_entry (
        .clk         (clk),
        .rst         (rst),
        .arm         (cfg_pfm_en && !in_pfm),
        .strobe      (cyc_strobe),
        .sample      (cur_sample),
        .thresh      (cfg_cur_thresh),
        .limit_we    (cfg_entry_we),
        .limit_wdata (cfg_entry_cycles),
        .enter_req   (enter_req)
    );

    llm_window #(
        .REF_W (REF_W),
        .OFF_W (OFF_W)
    ) u_window (
        .clk    (clk),
        .rst    (rst),
        .vref   (vref_code),
        .hi_off (cfg_win_hi),
        .lo_off (cfg_win_lo),
        .lim_hi (win_hi_lim),
        .lim_lo (win_lo_lim)
    );

    llm_pfm_trigger #(
        .DZ_W (DZ_W)
    ) u_trig (
        .clk        (clk),
        .rst        (rst),
        .pfm_active (pfm_active),
        .below_ref  (flags.below_ref),
        .busy       (mod_busy),
        .trig       (pfm_trig),
        .dz_ticks   (dead_zone_ticks)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_PWM;
            chg_q  <= 1'b0;
        end else begin
            chg_q <= 1'b0;
            if (exit_now) begin
                mode_q <= MODE_PWM;
                chg_q  <= 1'b1;
            end else if (enter_req) begin
                mode_q <= MODE_PFM;
                chg_q  <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            duty_hold_q <= '0;
        end else if (!in_pfm) begin
            duty_hold_q <= pwm_duty;
        end
    end

    assign pfm_mode = in_pfm;
    assign mode_chg = chg_q;
    assign duty_out = in_pfm ? duty_hold_q : pwm_duty;

    assert_disabled_stays_pwm_R5: assert property (@(posedge clk) disable iff (rst)
        !cfg_pfm_en |=> !pfm_mode);

    assert_window_exit_R8: assert property (@(posedge clk) disable iff (rst)
        (pfm_mode && (cmp_above_hi || cmp_below_lo)) |=> (!pfm_mode && !pfm_trig));

    assert_duty_frozen_R6: assert property (@(posedge clk) disable iff (rst)
        (pfm_mode && $past(pfm_mode)) |-> $stable(duty_out));

    assert_chg_marks_edge_R11: assert property (@(posedge clk) disable iff (rst)
        mode_chg |-> (pfm_mode != $past(pfm_mode)));

    assert_entry_on_strobe_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(pfm_mode) |-> $past(cyc_strobe && cfg_pfm_en));

endmodule

// File: tb/lightload_mode_ctrl_test.sv
`timescale 1ns/1ps
module lightload_mode_ctrl_test;

    localparam int CUR_W = 10, CNT_W = 8, REF_W = 10, OFF_W = 8, DUTY_W = 12, DZ_W = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_pfm_en = 1'b0;
    logic [CUR_W-1:0] cfg_cur_thresh = '0;
    logic cfg_entry_we = 1'b0;
    logic [CNT_W-1:0] cfg_entry_cycles = '0;
    logic [OFF_W-1:0] cfg_win_hi = '0;
    logic [OFF_W-1:0] cfg_win_lo = '0;
    logic [REF_W-1:0] vref_code = '0;
    logic cyc_strobe = 1'b0;
    logic [CUR_W-1:0] cur_sample = '0;
    logic [DUTY_W-1:0] pwm_duty = '0;
    logic cmp_below_ref = 1'b0;
    logic cmp_above_hi = 1'b0;
    logic cmp_below_lo = 1'b0;
    logic mod_busy = 1'b0;
    logic pfm_mode, mode_chg, pfm_trig;
    logic [DUTY_W-1:0] duty_out;
    logic [REF_W-1:0] win_hi_lim, win_lo_lim;
    logic [DZ_W-1:0] dead_zone_ticks;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    lightload_mode_ctrl uut (
        .clk(clk), .rst(rst), .cfg_pfm_en(cfg_pfm_en), .cfg_cur_thresh(cfg_cur_thresh),
        .cfg_entry_we(cfg_entry_we), .cfg_entry_cycles(cfg_entry_cycles),
        .cfg_win_hi(cfg_win_hi), .cfg_win_lo(cfg_win_lo), .vref_code(vref_code),
        .cyc_strobe(cyc_strobe), .cur_sample(cur_sample), .pwm_duty(pwm_duty),
        .cmp_below_ref(cmp_below_ref), .cmp_above_hi(cmp_above_hi), .cmp_below_lo(cmp_below_lo),
        .mod_busy(mod_busy), .pfm_mode(pfm_mode), .mode_chg(mode_chg), .pfm_trig(pfm_trig),
        .duty_out(duty_out), .win_hi_lim(win_hi_lim), .win_lo_lim(win_lo_lim),
        .dead_zone_ticks(dead_zone_ticks)
    );

    function automatic int exp_hi(int v, int h);
        return (v + h > 1023) ? 1023 : v + h;
    endfunction

    function automatic int exp_lo(int v, int l);
        return (l > v) ? 0 : v - l;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic strobe(input int sample);
        cyc_strobe = 1'b1;
        cur_sample = CUR_W'(sample);
        tick();
        cyc_strobe = 1'b0;
    endtask

    task automatic write_run(input int n);
        cfg_entry_we = 1'b1;
        cfg_entry_cycles = CNT_W'(n);
        tick();
        cfg_entry_we = 1'b0;
    endtask

    task automatic leave_high();
        cmp_above_hi = 1'b1;
        tick();
        cmp_above_hi = 1'b0;
        tick();
    endtask

    task automatic summary();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            summary();
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'd4242);
        cfg_cur_thresh = 10'd100;
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R1 reset state
        chk("R1 pfm_mode", pfm_mode, 0);
        chk("R1 mode_chg", mode_chg, 0);
        chk("R1 pfm_trig", pfm_trig, 0);
        chk("R1 dead_zone", dead_zone_ticks, 0);

        // R5 disabled: many low samples, stays PWM
        for (int i = 0; i < 25; i++) strobe(5);
        chk("R5 disabled stays pwm", pfm_mode, 0);

        // R1/R2 default run of 20
        cfg_pfm_en = 1'b1;
        pwm_duty = 12'd700;
        for (int i = 0; i < 19; i++) strobe(40);
        chk("R1 default run 19 not enough", pfm_mode, 0);
        pwm_duty = 12'd1234;
        strobe(99);
        chk("R2 entry at 20th", pfm_mode, 1);
        chk("R11 chg on entry", mode_chg, 1);
        pwm_duty = 12'd55;
        tick();
        chk("R11 chg single", mode_chg, 0);
        chk("R6 duty frozen", duty_out, 1234);

        // R7 / R10 dead zone
        mod_busy = 1'b1;
        tick();
        mod_busy = 1'b0;
        repeat (5) tick();
        cmp_below_ref = 1'b1;
        tick();
        chk("R7 trig fires", pfm_trig, 1);
        chk("R10 dead zone", dead_zone_ticks, 5);
        tick();
        chk("R7 one shot", pfm_trig, 0);
        tick();
        chk("R7 no retrigger while held", pfm_trig, 0);
        // busy blocks edge
        cmp_below_ref = 1'b0;
        mod_busy = 1'b1;
        tick();
        cmp_below_ref = 1'b1;
        tick();
        chk("R7 busy blocks", pfm_trig, 0);
        mod_busy = 1'b0;
        tick();
        tick();
        chk("R7 dropped edge stays dropped", pfm_trig, 0);
        chk("R10 held between triggers", dead_zone_ticks, 5);

        // R8 collision: below_ref rises with below_lo
        cmp_below_ref = 1'b0;
        tick();
        cmp_below_ref = 1'b1;
        cmp_below_lo = 1'b1;
        tick();
        chk("R8 exit low", pfm_mode, 0);
        chk("R8 no trig on exit", pfm_trig, 0);
        chk("R11 chg on exit", mode_chg, 1);
        cmp_below_lo = 1'b0;
        cmp_below_ref = 1'b0;
        tick();
        chk("R6 passthrough", duty_out, 55);
        // R7 no trigger in PWM
        cmp_below_ref = 1'b1;
        tick();
        chk("R7 none in pwm", pfm_trig, 0);
        cmp_below_ref = 1'b0;

        // R4 write run 4, R3 clear
        write_run(4);
        for (int i = 0; i < 3; i++) strobe(10);
        strobe(100);
        chk("R3 sample at threshold clears", pfm_mode, 0);
        for (int i = 0; i < 3; i++) strobe(10);
        chk("R3 run restarted", pfm_mode, 0);
        strobe(10);
        chk("R4 run of 4", pfm_mode, 1);
        // R8 collision with above_hi
        tick();
        cmp_below_ref = 1'b1;
        cmp_above_hi = 1'b1;
        tick();
        chk("R8 exit high", pfm_mode, 0);
        chk("R8 no trig high", pfm_trig, 0);
        cmp_above_hi = 1'b0;
        cmp_below_ref = 1'b0;
        tick();

        // R4 zero acts as one
        write_run(0);
        strobe(3);
        chk("R4 zero acts as one", pfm_mode, 1);
        // R5 disable in PFM
        tick();
        cfg_pfm_en = 1'b0;
        tick();
        chk("R5 disable exits", pfm_mode, 0);
        chk("R11 chg on disable", mode_chg, 1);
        cfg_pfm_en = 1'b1;

        // R9 random window limits, with directed corners
        vref_code = 10'd1020; cfg_win_hi = 8'd200; cfg_win_lo = 8'd30;
        #1;
        chk("R9 hi saturates", win_hi_lim, 1023);
        chk("R9 lo normal", win_lo_lim, 990);
        vref_code = 10'd10; cfg_win_hi = 8'd5; cfg_win_lo = 8'd50;
        #1;
        chk("R9 lo floors", win_lo_lim, 0);
        for (int i = 0; i < 30; i++) begin
            int v, h, l;
            v = $urandom_range(1023, 0);
            h = $urandom_range(255, 0);
            l = $urandom_range(255, 0);
            vref_code = REF_W'(v); cfg_win_hi = OFF_W'(h); cfg_win_lo = OFF_W'(l);
            tick();
            chk("R9 rand hi", win_hi_lim, exp_hi(v, h));
            chk("R9 rand lo", win_lo_lim, exp_lo(v, l));
        end

        // R2/R6/R10 random runs
        for (int i = 0; i < 12; i++) begin
            int n, d, m;
            n = $urandom_range(8, 1);
            d = $urandom_range(4095, 0);
            m = $urandom_range(20, 1);
            write_run(n);
            for (int k = 0; k < n - 1; k++) strobe($urandom_range(99, 0));
            chk("R2 rand not yet", pfm_mode, 0);
            pwm_duty = DUTY_W'(d);
            strobe($urandom_range(99, 0));
            chk("R2 rand entry", pfm_mode, 1);
            pwm_duty = DUTY_W'($urandom_range(4095, 0));
            mod_busy = 1'b1;
            tick();
            mod_busy = 1'b0;
            repeat (m) tick();
            cmp_below_ref = 1'b1;
            tick();
            chk("R7 rand trig", pfm_trig, 1);
            chk("R10 rand dead zone", dead_zone_ticks, m);
            chk("R6 rand frozen", duty_out, d);
            cmp_below_ref = 1'b0;
            leave_high();
            chk("R8 rand exit", pfm_mode, 0);
        end

        finished = 1;
        summary();
        $finish;
    end

endmodule